// File: doc/BRIEF.md
# Flash Write-Protect Arbiter

This block decides whether a command that alters a serial flash array may go ahead. It holds the protection part of the status byte: a status-lock bit and a two-bit protect-size field. It also samples an active-low protect pin. The protect-size field marks a region at the top of the address space as read-only. That region is combined with a per-sector lock flag supplied by a neighbouring lock unit.

A front end presents one command per cycle with a class code, a target address, the write-enable latch level, the lock flags and, for a status write, the new status byte. One clock later the block returns a valid strobe and a permit bit. An accepted status write updates the stored bits on that same edge.

The status-lock bit and the pin together form a hardware mode. While the pin is low and the status-lock bit is set, the protect bits are frozen, so the size of the protected area cannot change. This hardware mode stacks with the region protection and with the sector locks.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and both the valid strobe and the permit bit are 0.
- R2: The valid strobe is 1 in exactly the cycle after one in which `cmd_valid` was 1, and 0 otherwise. The permit bit is 0 whenever the strobe is 0. Class codes are: 0 read, 1 page write, 2 page program, 3 page erase, 4 subsector erase, 5 sector erase, 6 bulk erase, 7 status write.
- R3: A status write with the write-enable latch at 0 is refused and leaves the status byte unchanged.
- R4: When the status-lock bit (status bit 7) is 1 and the pin, as registered at the previous clock edge, is low, a status write is refused and the status byte stays unchanged.
- R5: With the write-enable latch at 1, a status write is accepted if the registered pin is high or the status-lock bit is 0. Bit 7 of the data is stored as the status-lock bit and bits 3:2 as the protect field. All other status bits always read 0.
- R6: The protect field selects the protected top region: 00 none, 01 the top quarter, 10 the top half, 11 the whole array. Regions are bounded by the two most significant address bits.
- R7: A page write, page program, page erase, subsector erase or sector erase is permitted only if the write-enable latch is 1 and its address lies outside the protected region.
- R8: Any command of classes 1 to 5 is refused while `sect_locked` is 1.
- R9: A bulk erase is permitted only if the write-enable latch is 1, the protect field is 00 and `any_locked` is 0.
- R10: A read (class 0) is always permitted, whatever the latch, pin and lock inputs.
- R11: A command of classes 1 to 7 with the write-enable latch at 0 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin_n | input | 1 | Write-protect pin, low means protect |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_class | input | 3 | Command class code |
| cmd_addr | input | ADDR_W | Target byte address |
| wel | input | 1 | Write-enable latch level |
| sect_locked | input | 1 | Lock flag of the addressed sector |
| any_locked | input | 1 | At least one sector is locked |
| sr_wdata | input | 8 | New status byte for a status write |
| grant_vld | output | 1 | Decision strobe, one cycle after the command |
| grant | output | 1 | Command permitted |
| status | output | 8 | Stored status byte |

## Verification
Addresses are placed at both sides of each quarter and half boundary under every protect-field value. This separates an off-by-one boundary from a wrong field decode. Status writes are tried with the pin high and low, with the lock bit set and clear, and with the pin changed one cycle before the command. These cases separate the hardware freeze from the plain latch check and expose a pin that is used unregistered. Bulk erase is tried under a clear field, a non-zero field and a sector lock, which shows whether all three conditions are combined.

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_class,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wel,
  input  logic              sect_locked,
  input  logic              any_locked,
  input  logic [7:0]        sr_wdata,
  output logic              grant_vld,
  output logic              grant,
  output logic [7:0]        status
);
  localparam logic [2:0] CL_READ = 3'd0;
  localparam logic [2:0] CL_BULK = 3'd6;
  localparam logic [2:0] CL_STAT = 3'd7;
  localparam logic [7:0] STAT_MASK = 8'h8C;
  localparam logic [ADDR_W-1:0] BASE_HALF = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] BASE_QTR  = ADDR_W'(3) << (ADDR_W - 2);

  logic [7:0]        stat_q;
  logic              pin_q;
  logic [1:0]        bp;
  logic              lock_bit;
  logic              frozen;
  logic              in_region;
  logic [ADDR_W-1:0] prot_base;
  logic              ok;

  assign bp       = stat_q[3:2];
  assign lock_bit = stat_q[7];
  assign frozen   = lock_bit & ~pin_q;
  assign status   = stat_q;

  always_comb begin
    case (bp)
      2'b01:   prot_base = BASE_QTR;
      2'b10:   prot_base = BASE_HALF;
      default: prot_base = '0;
    endcase
  end

  assign in_region = (bp != 2'b00) && (cmd_addr >= prot_base);

  always_comb begin
    case (cmd_class)
      CL_READ: ok = 1'b1;
      CL_BULK: ok = wel & (bp == 2'b00) & ~any_locked;
      CL_STAT: ok = wel & ~frozen;
      default: ok = wel & ~in_region & ~sect_locked;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q     <= 1'b0;
      stat_q    <= 8'h00;
      grant_vld <= 1'b0;
      grant     <= 1'b0;
    end else begin
      pin_q     <= wp_pin_n;
      grant_vld <= cmd_valid;
      grant     <= cmd_valid & ok;
      if (cmd_valid && cmd_class == CL_STAT && ok)
        stat_q <= sr_wdata & STAT_MASK;
    end
  end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_class,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wel,
  input logic              sect_locked,
  input logic              any_locked,
  input logic              grant_vld,
  input logic              grant,
  input logic [7:0]        status
);
  logic modify;
  assign modify = (cmd_class >= 3'd1) && (cmd_class <= 3'd5);

  // R2
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> grant_vld);

  // R2
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!grant_vld && !grant));

  // R11
  need_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !wel && cmd_class != 3'd0) |=> !grant);

  // R8
  sect_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && sect_locked && modify) |=> !grant);

  // R9
  bulk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 3'd6 && (any_locked || status[3:2] != 2'b00)) |=> !grant);

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_class == 3'd7 && wel) |=> $stable(status));

  // R10
  read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_class == 3'd0) |=> grant);

  // R6
  full_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && modify && status[3:2] == 2'b11) |=> !grant);

  // R5
  always_comb begin
    if (rst_n) unused_zero_chk: assert ((status & 8'h73) == 8'h00);
  end

  logic unused_addr;
  assign unused_addr = ^cmd_addr;
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
  .cmd_addr(cmd_addr), .wel(wel), .sect_locked(sect_locked),
  .any_locked(any_locked), .grant_vld(grant_vld), .grant(grant),
  .status(status)
);

// File: tb/wp_guard_tb_top.sv
module wp_guard_tb_top;
  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_pin_n = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_class = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic          wel = 1'b0;
  logic          sect_locked = 1'b0;
  logic          any_locked = 1'b0;
  logic [7:0]    sr_wdata = 8'h00;
  logic          grant_vld, grant;
  logic [7:0]    status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  int m_srwd = 0, m_bp = 0, m_pin = 0, m_gv = 0, m_g = 0;

  always #4 clk = ~clk;

  wp_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_pin_n(wp_pin_n), .cmd_valid(cmd_valid),
    .cmd_class(cmd_class), .cmd_addr(cmd_addr), .wel(wel),
    .sect_locked(sect_locked), .any_locked(any_locked), .sr_wdata(sr_wdata),
    .grant_vld(grant_vld), .grant(grant), .status(status)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_srwd = 0; m_bp = 0; m_pin = 0; m_gv = 0; m_g = 0;
    end else begin
      int top;
      bit prot;
      m_gv = cmd_valid;
      m_g = 0;
      top = int'(cmd_addr) / (1 << (AW - 2));
      prot = (m_bp == 3) || (m_bp == 2 && top >= 2) || (m_bp == 1 && top == 3);
      if (cmd_valid) begin
        case (cmd_class)
          3'd0: m_g = 1;
          3'd6: m_g = wel && m_bp == 0 && !any_locked;
          3'd7: begin
            m_g = wel && !(m_srwd == 1 && m_pin == 0);
            if (m_g) begin
              m_srwd = sr_wdata[7];
              m_bp = int'(sr_wdata[3:2]);
            end
          end
          default: m_g = wel && !prot && !sect_locked;
        endcase
      end
      m_pin = wp_pin_n;
    end
  end

  task automatic compare(input string req);
    int exp_st;
    exp_st = m_srwd * 128 + m_bp * 4;
    checks++;
    if (grant_vld !== m_gv[0] || grant !== m_g[0] || status !== 8'(exp_st)) begin
      errors++;
      $display("FAIL %s: vld/grant/status actual %0b/%0b/%02h expected %0d/%0d/%02h",
               req, grant_vld, grant, status, m_gv, m_g, exp_st);
    end
  endtask

  task automatic step(input string req, input bit v, input int cls, input int addr,
                      input bit w, input bit pin, input bit lk, input bit alk,
                      input int wd);
    cur_req = req;
    cmd_valid = v; cmd_class = 3'(cls); cmd_addr = AW'(addr); wel = w;
    wp_pin_n = pin; sect_locked = lk; any_locked = alk; sr_wdata = 8'(wd);
    @(posedge clk);
    #2;
    compare(req);
  endtask

  localparam int QTR = 1 << (AW - 2);

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R1");
    rst_n = 1'b1;
    // R2 idle and back-to-back
    step("R2", 0, 1, 0, 1, 1, 0, 0, 0);
    step("R10", 1, 0, 5, 0, 0, 1, 1, 0);
    step("R10", 1, 0, 3*QTR, 0, 1, 1, 1, 0);
    step("R11", 1, 2, 0, 0, 1, 0, 0, 0);
    step("R11", 1, 7, 0, 0, 1, 0, 0, 8'h8C);
    step("R3", 0, 0, 0, 0, 1, 0, 0, 0);
    // R5 accept with pin high
    step("R5", 1, 7, 0, 1, 1, 0, 0, 8'hFF);
    step("R6", 1, 1, 0, 1, 1, 0, 0, 0);
    // R4 pin low one cycle before, then frozen
    step("R4", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R4", 1, 7, 0, 1, 0, 0, 0, 8'h00);
    step("R4", 1, 7, 0, 1, 1, 0, 0, 8'h04);
    step("R5", 1, 7, 0, 1, 1, 0, 0, 8'h04);
    step("R5", 1, 7, 0, 1, 0, 0, 0, 8'h08);
    step("R5", 1, 7, 0, 1, 0, 0, 0, 8'h88);
    step("R4", 1, 7, 0, 1, 0, 0, 0, 8'h00);
    step("R5", 0, 0, 0, 0, 1, 0, 0, 0);
    step("R5", 1, 7, 0, 1, 1, 0, 0, 8'h08);
    // R6/R7 boundary sweep under each field
    for (int b = 3; b >= 0; b--) begin
      step("R5", 1, 7, 0, 1, 1, 0, 0, b * 4);
      for (int c = 1; c <= 5; c++) begin
        step("R7", 1, c, 2*QTR - 1, 1, 1, 0, 0, 0);
        step("R7", 1, c, 2*QTR, 1, 1, 0, 0, 0);
        step("R6", 1, c, 3*QTR - 1, 1, 1, 0, 0, 0);
        step("R6", 1, c, 3*QTR, 1, 1, 0, 0, 0);
        step("R6", 1, c, 4*QTR - 1, 1, 0, 0, 0, 0);
        step("R7", 1, c, 0, 1, 1, 0, 0, 0);
      end
      step("R9", 1, 6, 0, 1, 1, 0, 0, 0);
      step("R9", 1, 6, 0, 1, 1, 0, 1, 0);
    end
    // R8 sector locks with field clear
    for (int c = 1; c <= 5; c++) begin
      step("R8", 1, c, 100, 1, 1, 1, 0, 0);
      step("R8", 1, c, 100, 1, 1, 0, 1, 0);
    end
    step("R11", 1, 6, 0, 0, 1, 0, 0, 0);
    step("R3", 1, 7, 0, 0, 1, 0, 0, 8'h8C);
    step("R2", 0, 7, 0, 1, 1, 0, 0, 8'h8C);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog %s: actual hung expected finished", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule